// File: doc/BRIEF.md
# Register Vector-Attribute Lookup Unit

This unit sits beside instruction decode. For each operand of the instruction being decoded, it returns the vector length and packed element width that apply to that register. It then sorts the instruction into one of four execution modes and flags illegal length combinations. The per-register attributes come from two sources. The first is a pair of per-register "marked as vector" masks, one for the integer bank and one for the floating-point bank. The second is a small priority table whose entries each bind one register of one bank to a length and an element-width code.

Configuration is loaded through a single write port, one word per cycle. The three operand lookups (rd, rs1, rs2) and the classification are purely combinational over the stored configuration. A write therefore affects every lookup from the clock edge that captures it. Operand enables let decode exclude operands that an instruction does not use from mode and exception decisions.

Top module: `vattr_lookup_unit`

## Requirements
- R1: After reset both masks are clear and every operand reads length 1 and width code 0. The mode is 0 (scalar) and no exception cause is set.
- R2: Write port address 0 loads the integer mask and address 1 loads the floating-point mask, where bit n covers register n. Address 2+k loads table entry k with these fields: register index in data[4:0], bank in data[5] (1 = floating point), width code in data[7:6] and length in data[15:8].
- R3: An operand whose mask bit is clear in its own bank reads length 1 and width code 0, even when a table entry names it.
- R4: For a marked operand, the entries are scanned from index 0 upward. The first entry with the same register index and bank supplies the length and width code, so entry 0 wins over entry 1.
- R5: A marked operand that matches no entry reads length 1 and width code 0, where width code 0 means the opcode's default width.
- R6: A stored length of 0 is reported as 1.
- R7: The mode is taken over enabled operands only. Mode 1 means some length is above 1 and all widths are default. Mode 2 means some width code is non-zero and all lengths are 1. Mode 3 means both conditions hold, and mode 0 means neither does.
- R8: Cause bit 0 is set when rs1 and rs2 are both enabled, both have length above 1, and their lengths differ.
- R9: Cause bit 1 is set when rd is enabled with length above 1 and an enabled source is longer than rd. A length-1 rd allows any source length.
- R10: Cause bit 2 is set when the jump-and-link-register indicator is high and rs1's bit in the integer mask is set.
- R11: The exception output is the OR of the three cause bits. Lookups and classification are combinational and reflect a write from the edge that captures it.
- R12: Table matches are bank-specific: an integer entry for register n does not match floating-point register n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 2 | Configuration word select |
| wr_data | input | 32 | Configuration write data |
| rd_idx | input | 5 | Destination register number |
| rd_fp | input | 1 | Destination is in the floating-point bank |
| rd_en | input | 1 | Destination is used |
| rs1_idx | input | 5 | First source register number |
| rs1_fp | input | 1 | First source is in the floating-point bank |
| rs1_en | input | 1 | First source is used |
| rs2_idx | input | 5 | Second source register number |
| rs2_fp | input | 1 | Second source is in the floating-point bank |
| rs2_en | input | 1 | Second source is used |
| is_jalr | input | 1 | Instruction is a jump-and-link-register |
| rd_vlen | output | 8 | Effective length of rd |
| rd_wcode | output | 2 | Width code of rd (0 default, 1 = 8, 2 = 16, 3 = 32 bits) |
| rs1_vlen | output | 8 | Effective length of rs1 |
| rs1_wcode | output | 2 | Width code of rs1 |
| rs2_vlen | output | 8 | Effective length of rs2 |
| rs2_wcode | output | 2 | Width code of rs2 |
| mode | output | 2 | Execution mode (0 scalar, 1 loop, 2 packed, 3 loop+packed) |
| exc | output | 1 | Any exception cause set |
| exc_cause | output | 3 | Cause bits: 0 length mismatch, 1 source longer, 2 marked jump target |

## Verification
Every cycle, the assertions check four things. A scalar mode never coexists with an enabled non-unit operand. Each cause bit is only set when its triggering condition is visible at the ports. No reported length is zero. Configuration words land in the addressed register and stay put without a write. Only the bench scenarios can show the lookup outcome itself. This covers first-match priority between overlapping entries, bank separation, masking by a clear flag, and that a reduction-shaped instruction raises nothing. The bench checks these against a model kept from its own writes.

// File: rtl/vattr_pkg.sv
package vattr_pkg;
    typedef enum logic [1:0] {
        MODE_SCALAR      = 2'd0,
        MODE_LOOP        = 2'd1,
        MODE_PACKED      = 2'd2,
        MODE_LOOP_PACKED = 2'd3
    } vmode_e;

    localparam int WCODE_W      = 2;
    localparam int CAUSE_MISMATCH = 0;
    localparam int CAUSE_SRC_LONG = 1;
    localparam int CAUSE_JALR     = 2;
    localparam int CAUSE_N        = 3;
    localparam int N_OPS          = 3;
endpackage

// File: rtl/vattr_cfg_store.sv
module vattr_cfg_store
    import vattr_pkg::*;
#(
    parameter int NREGS  = 32,
    parameter int NENTRY = 2,
    parameter int VL_W   = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W  = $clog2(NREGS),
    localparam int ADDR_W = $clog2(NENTRY + 2)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    output logic [NREGS-1:0]                  int_mask,
    output logic [NREGS-1:0]                  fp_mask,
    output logic [NENTRY-1:0][IDX_W-1:0]      ent_idx,
    output logic [NENTRY-1:0]                 ent_fp,
    output logic [NENTRY-1:0][WCODE_W-1:0]    ent_wc,
    output logic [NENTRY-1:0][VL_W-1:0]       ent_vl
);
    localparam int BANK_BIT = IDX_W;
    localparam int WC_LO    = IDX_W + 1;
    localparam int VL_LO    = WC_LO + WCODE_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_mask <= '0;
            fp_mask  <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(0)) int_mask <= wr_data[NREGS-1:0];
            if (wr_addr == ADDR_W'(1)) fp_mask  <= wr_data[NREGS-1:0];
        end
    end

    for (genvar k = 0; k < NENTRY; k++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_idx[k] <= '0;
                ent_fp[k]  <= 1'b0;
                ent_wc[k]  <= '0;
                ent_vl[k]  <= VL_W'(1);
            end else if (wr_en && wr_addr == ADDR_W'(k + 2)) begin
                ent_idx[k] <= wr_data[IDX_W-1:0];
                ent_fp[k]  <= wr_data[BANK_BIT];
                ent_wc[k]  <= wr_data[WC_LO +: WCODE_W];
                ent_vl[k]  <= wr_data[VL_LO +: VL_W];
            end
        end
    end

    // R2
    int_mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(0)) |=> int_mask == $past(wr_data[NREGS-1:0]));
    // R2
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(int_mask) && $stable(fp_mask)));
    // R2
    ent0_len_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(2)) |=> ent_vl[0] == $past(wr_data[VL_LO +: VL_W]));
endmodule

// File: rtl/vattr_operand_lookup.sv
module vattr_operand_lookup
    import vattr_pkg::*;
#(
    parameter int NREGS  = 32,
    parameter int NENTRY = 2,
    parameter int VL_W   = 8,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic [IDX_W-1:0]                  reg_idx,
    input  logic                              reg_fp,
    input  logic [NREGS-1:0]                  int_mask,
    input  logic [NREGS-1:0]                  fp_mask,
    input  logic [NENTRY-1:0][IDX_W-1:0]      ent_idx,
    input  logic [NENTRY-1:0]                 ent_fp,
    input  logic [NENTRY-1:0][WCODE_W-1:0]    ent_wc,
    input  logic [NENTRY-1:0][VL_W-1:0]       ent_vl,
    output logic [VL_W-1:0]                   vlen,
    output logic [WCODE_W-1:0]                wcode
);
    logic marked;
    logic hit;

    always_comb begin
        marked = reg_fp ? fp_mask[reg_idx] : int_mask[reg_idx];
        hit    = 1'b0;
        vlen   = VL_W'(1);
        wcode  = '0;
        for (int k = 0; k < NENTRY; k++) begin
            if (!hit && ent_idx[k] == reg_idx && ent_fp[k] == reg_fp) begin
                hit   = 1'b1;
                vlen  = (ent_vl[k] == '0) ? VL_W'(1) : ent_vl[k];
                wcode = ent_wc[k];
            end
        end
        if (!marked) begin
            vlen  = VL_W'(1);
            wcode = '0;
        end
    end
endmodule

// File: rtl/vattr_classify.sv
module vattr_classify
    import vattr_pkg::*;
#(
    parameter int VL_W = 8
) (
    input  logic [VL_W-1:0]    rd_vl,
    input  logic [VL_W-1:0]    rs1_vl,
    input  logic [VL_W-1:0]    rs2_vl,
    input  logic [WCODE_W-1:0] rd_wc,
    input  logic [WCODE_W-1:0] rs1_wc,
    input  logic [WCODE_W-1:0] rs2_wc,
    input  logic               rd_en,
    input  logic               rs1_en,
    input  logic               rs2_en,
    input  logic               is_jalr,
    input  logic               rs1_int_marked,
    output vmode_e             mode,
    output logic [CAUSE_N-1:0] cause
);
    logic rd_vec, rs1_vec, rs2_vec;
    logic any_loop, any_packed;

    always_comb begin
        rd_vec  = rd_en  && (rd_vl  > VL_W'(1));
        rs1_vec = rs1_en && (rs1_vl > VL_W'(1));
        rs2_vec = rs2_en && (rs2_vl > VL_W'(1));

        any_loop   = rd_vec || rs1_vec || rs2_vec;
        any_packed = (rd_en  && rd_wc  != '0) ||
                     (rs1_en && rs1_wc != '0) ||
                     (rs2_en && rs2_wc != '0);

        unique case ({any_loop, any_packed})
            2'b00:   mode = MODE_SCALAR;
            2'b10:   mode = MODE_LOOP;
            2'b01:   mode = MODE_PACKED;
            default: mode = MODE_LOOP_PACKED;
        endcase

        cause = '0;
        cause[CAUSE_MISMATCH] = rs1_vec && rs2_vec && (rs1_vl != rs2_vl);
        cause[CAUSE_SRC_LONG] = rd_vec &&
                                ((rs1_en && rs1_vl > rd_vl) || (rs2_en && rs2_vl > rd_vl));
        cause[CAUSE_JALR]     = is_jalr && rs1_int_marked;
    end
endmodule

// File: rtl/vattr_lookup_unit.sv
module vattr_lookup_unit
    import vattr_pkg::*;
#(
    parameter int NREGS  = 32,
    parameter int NENTRY = 2,
    parameter int VL_W   = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W  = $clog2(NREGS),
    localparam int ADDR_W = $clog2(NENTRY + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic               rd_fp,
    input  logic               rd_en,
    input  logic [IDX_W-1:0]   rs1_idx,
    input  logic               rs1_fp,
    input  logic               rs1_en,
    input  logic [IDX_W-1:0]   rs2_idx,
    input  logic               rs2_fp,
    input  logic               rs2_en,
    input  logic               is_jalr,
    output logic [VL_W-1:0]    rd_vlen,
    output logic [1:0]         rd_wcode,
    output logic [VL_W-1:0]    rs1_vlen,
    output logic [1:0]         rs1_wcode,
    output logic [VL_W-1:0]    rs2_vlen,
    output logic [1:0]         rs2_wcode,
    output logic [1:0]         mode,
    output logic               exc,
    output logic [2:0]         exc_cause
);
    logic [NREGS-1:0]               int_mask, fp_mask;
    logic [NENTRY-1:0][IDX_W-1:0]   ent_idx;
    logic [NENTRY-1:0]              ent_fp;
    logic [NENTRY-1:0][WCODE_W-1:0] ent_wc;
    logic [NENTRY-1:0][VL_W-1:0]    ent_vl;

    logic [N_OPS-1:0][IDX_W-1:0]    op_idx;
    logic [N_OPS-1:0]               op_fp;
    logic [N_OPS-1:0][VL_W-1:0]     op_vl;
    logic [N_OPS-1:0][WCODE_W-1:0]  op_wc;
    vmode_e                         mode_q;
    logic [CAUSE_N-1:0]             cause;

    vattr_cfg_store #(
        .NREGS(NREGS), .NENTRY(NENTRY), .VL_W(VL_W), .DATA_W(DATA_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .int_mask(int_mask), .fp_mask(fp_mask),
        .ent_idx(ent_idx), .ent_fp(ent_fp), .ent_wc(ent_wc), .ent_vl(ent_vl)
    );

    assign op_idx = {rs2_idx, rs1_idx, rd_idx};
    assign op_fp  = {rs2_fp, rs1_fp, rd_fp};

    for (genvar o = 0; o < N_OPS; o++) begin : g_op
        vattr_operand_lookup #(
            .NREGS(NREGS), .NENTRY(NENTRY), .VL_W(VL_W)
        ) u_look (
            .reg_idx(op_idx[o]), .reg_fp(op_fp[o]),
            .int_mask(int_mask), .fp_mask(fp_mask),
            .ent_idx(ent_idx), .ent_fp(ent_fp), .ent_wc(ent_wc), .ent_vl(ent_vl),
            .vlen(op_vl[o]), .wcode(op_wc[o])
        );
    end

    vattr_classify #(.VL_W(VL_W)) u_cls (
        .rd_vl(op_vl[0]), .rs1_vl(op_vl[1]), .rs2_vl(op_vl[2]),
        .rd_wc(op_wc[0]), .rs1_wc(op_wc[1]), .rs2_wc(op_wc[2]),
        .rd_en(rd_en), .rs1_en(rs1_en), .rs2_en(rs2_en),
        .is_jalr(is_jalr), .rs1_int_marked(int_mask[rs1_idx]),
        .mode(mode_q), .cause(cause)
    );

    assign rd_vlen   = op_vl[0];
    assign rs1_vlen  = op_vl[1];
    assign rs2_vlen  = op_vl[2];
    assign rd_wcode  = op_wc[0];
    assign rs1_wcode = op_wc[1];
    assign rs2_wcode = op_wc[2];
    assign mode      = mode_q;
    assign exc_cause = cause;
    assign exc       = |cause;

    // R7
    scalar_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |-> !((rd_en && rd_vlen != VL_W'(1)) || (rs1_en && rs1_vlen != VL_W'(1))
                            || (rs2_en && rs2_vlen != VL_W'(1))));
    // R8
    mismatch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_cause[0] |-> (rs1_en && rs2_en && rs1_vlen != rs2_vlen));
    // R9
    src_long_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_cause[1] |-> (rd_en && rd_vlen > VL_W'(1)));
    // R10
    jalr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_cause[2] |-> is_jalr);
    // R6
    vlen_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vlen != '0 && rs1_vlen != '0 && rs2_vlen != '0));
endmodule

// File: tb/vattr_lookup_unit_tb.sv
module vattr_lookup_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_idx = '0, rs1_idx = '0, rs2_idx = '0;
    logic        rd_fp = 1'b0, rs1_fp = 1'b0, rs2_fp = 1'b0;
    logic        rd_en = 1'b0, rs1_en = 1'b0, rs2_en = 1'b0;
    logic        is_jalr = 1'b0;
    logic [7:0]  rd_vlen, rs1_vlen, rs2_vlen;
    logic [1:0]  rd_wcode, rs1_wcode, rs2_wcode, mode;
    logic        exc;
    logic [2:0]  exc_cause;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_int = '0, m_fpm = '0;
    int m_idx[2] = '{0, 0};
    bit m_bank[2] = '{0, 0};
    int m_wc[2] = '{0, 0};
    int m_vl[2] = '{1, 1};

    always #5 clk = ~clk;

    vattr_lookup_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_fp(rd_fp), .rd_en(rd_en),
        .rs1_idx(rs1_idx), .rs1_fp(rs1_fp), .rs1_en(rs1_en),
        .rs2_idx(rs2_idx), .rs2_fp(rs2_fp), .rs2_en(rs2_en),
        .is_jalr(is_jalr),
        .rd_vlen(rd_vlen), .rd_wcode(rd_wcode), .rs1_vlen(rs1_vlen), .rs1_wcode(rs1_wcode),
        .rs2_vlen(rs2_vlen), .rs2_wcode(rs2_wcode), .mode(mode), .exc(exc), .exc_cause(exc_cause)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic cfg_write(input int addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr[1:0]; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        if (addr == 0) m_int = data;
        else if (addr == 1) m_fpm = data;
        else begin
            m_idx[addr-2]  = int'(data[4:0]);
            m_bank[addr-2] = data[5];
            m_wc[addr-2]   = int'(data[7:6]);
            m_vl[addr-2]   = int'(data[15:8]);
        end
    endtask

    task automatic wr_entry(input int k, input int idx, input bit bank, input int wc, input int vl);
        logic [31:0] d;
        d = {16'd0, 8'(vl), 2'(wc), bank, 5'(idx)};
        cfg_write(k + 2, d);
    endtask

    function automatic void exp_look(input int idx, input bit fp, output int vl, output int wc);
        bit marked;
        marked = fp ? m_fpm[idx] : m_int[idx];
        vl = 1; wc = 0;
        if (!marked) return;
        for (int k = 0; k < 2; k++) begin
            if (m_idx[k] == idx && m_bank[k] == fp) begin
                vl = (m_vl[k] == 0) ? 1 : m_vl[k];
                wc = m_wc[k];
                return;
            end
        end
    endfunction

    task automatic set_ops(input int d, input bit dfp, input bit den,
                           input int a, input bit afp, input bit aen,
                           input int b, input bit bfp, input bit ben, input bit j);
        @(negedge clk);
        rd_idx = 5'(d); rd_fp = dfp; rd_en = den;
        rs1_idx = 5'(a); rs1_fp = afp; rs1_en = aen;
        rs2_idx = 5'(b); rs2_fp = bfp; rs2_en = ben;
        is_jalr = j;
        #2;
    endtask

    task automatic check_all(input string ctx);
        int dvl, dwc, avl, awc, bvl, bwc, em, c0, c1, c2;
        bit lp, pk;
        exp_look(int'(rd_idx), rd_fp, dvl, dwc);
        exp_look(int'(rs1_idx), rs1_fp, avl, awc);
        exp_look(int'(rs2_idx), rs2_fp, bvl, bwc);
        lp = (rd_en && dvl > 1) || (rs1_en && avl > 1) || (rs2_en && bvl > 1);
        pk = (rd_en && dwc != 0) || (rs1_en && awc != 0) || (rs2_en && bwc != 0);
        em = (lp ? 1 : 0) + (pk ? 2 : 0);
        c0 = (rs1_en && rs2_en && avl > 1 && bvl > 1 && avl != bvl) ? 1 : 0;
        c1 = (rd_en && dvl > 1 && ((rs1_en && avl > dvl) || (rs2_en && bvl > dvl))) ? 1 : 0;
        c2 = (is_jalr && m_int[rs1_idx]) ? 1 : 0;
        check({"R4 rd_vlen ", ctx}, int'(rd_vlen), dvl);
        check({"R4 rd_wcode ", ctx}, int'(rd_wcode), dwc);
        check({"R4 rs1_vlen ", ctx}, int'(rs1_vlen), avl);
        check({"R4 rs1_wcode ", ctx}, int'(rs1_wcode), awc);
        check({"R4 rs2_vlen ", ctx}, int'(rs2_vlen), bvl);
        check({"R4 rs2_wcode ", ctx}, int'(rs2_wcode), bwc);
        check({"R7 mode ", ctx}, int'(mode), em);
        check({"R8 cause0 ", ctx}, int'(exc_cause[0]), c0);
        check({"R9 cause1 ", ctx}, int'(exc_cause[1]), c1);
        check({"R10 cause2 ", ctx}, int'(exc_cause[2]), c2);
        check({"R11 exc ", ctx}, int'(exc), (c0 | c1 | c2));
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        set_ops(3, 0, 1, 7, 1, 1, 0, 0, 1, 0);
        check("R1 rd_vlen", int'(rd_vlen), 1);
        check("R1 rs1_wcode", int'(rs1_wcode), 0);
        check("R1 mode", int'(mode), 0);
        check("R1 exc_cause", int'(exc_cause), 0);

        // R2, R4: overlapping entries for int reg 3, entry 0 must win
        cfg_write(0, 32'h0000_0018);
        wr_entry(0, 3, 0, 1, 4);
        wr_entry(1, 3, 0, 2, 6);
        set_ops(3, 0, 1, 3, 0, 1, 9, 0, 0, 0);
        check("R4 priority vlen", int'(rd_vlen), 4);
        check("R4 priority wcode", int'(rd_wcode), 1);
        check("R7 loop+packed", int'(mode), 3);
        check_all("dir_prio");

        // R12, R5: fp reg 3 marked but no fp entry
        cfg_write(1, 32'h0000_0008);
        set_ops(3, 1, 1, 0, 0, 0, 0, 0, 0, 0);
        check("R12 fp bank vlen", int'(rd_vlen), 1);
        check("R5 nomatch wcode", int'(rd_wcode), 0);

        // R3: entry names int reg 2 but its mask bit is clear
        wr_entry(1, 2, 0, 3, 5);
        set_ops(2, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        check("R3 unmarked vlen", int'(rd_vlen), 1);
        check("R3 unmarked mode", int'(mode), 0);

        // R6: stored length 0 on marked int reg 4
        wr_entry(1, 4, 0, 0, 0);
        set_ops(4, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        check("R6 zero length", int'(rd_vlen), 1);

        // R8: rs1 length 4 (reg 3), rs2 length 5 (reg 4)
        wr_entry(1, 4, 0, 0, 5);
        set_ops(0, 0, 0, 3, 0, 1, 4, 0, 1, 0);
        check("R8 mismatch", int'(exc_cause), 1);
        check("R11 exc", int'(exc), 1);

        // R9: vector rd length 4, rs2 length 5
        set_ops(3, 0, 1, 0, 0, 0, 4, 0, 1, 0);
        check("R9 src longer", int'(exc_cause), 2);
        // R9: scalar rd with long source allowed
        set_ops(0, 0, 1, 0, 0, 0, 4, 0, 1, 0);
        check("R9 scalar rd ok", int'(exc_cause), 0);

        // R10: jalr through marked int reg 3
        set_ops(1, 0, 1, 3, 0, 1, 0, 0, 0, 1);
        check("R10 jalr marked", int'(exc_cause[2]), 1);
        set_ops(1, 0, 1, 5, 0, 1, 0, 0, 0, 1);
        check("R10 jalr unmarked", int'(exc_cause[2]), 0);

        // random mix
        for (int it = 0; it < 400; it++) begin
            int sel;
            sel = int'($urandom_range(0, 3));
            if (sel == 0)      cfg_write(0, $urandom());
            else if (sel == 1) cfg_write(1, $urandom());
            else begin
                int lv;
                lv = int'($urandom_range(0, 5));
                if (lv == 5) lv = int'($urandom_range(0, 255));
                wr_entry(sel - 2, int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                         int'($urandom_range(0, 3)), lv);
            end
            for (int r = 0; r < 3; r++) begin
                set_ops(int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                        int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                        int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                        1'($urandom_range(0, 1)));
                check_all("rnd");
            end
        end
        finish_run();
    end
endmodule